// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer with Unlock Sequence

This block is a down counter of configurable width that serves either as a general-purpose timer or as a system watchdog. A simple register bus gives software access to a reload value, the live count, a control word, a sticky timer event flag and a sticky reset flag. A prescaler slows the decrement rate. In timer mode, expiry raises the event flag and an interrupt line. The counter then either reloads or stops.

In watchdog mode, expiry sends a one-cycle reset request to the system reset controller and records a sticky reset flag. Software can enter watchdog mode with an ordinary control write. It can leave that mode only by writing two fixed key words, one after the other, to a dedicated write-only unlock register. This prevents a runaway program from turning off the watchdog by accident.

The bus is a single-cycle write strobe with address and data. Reads are combinational on the address. Byte offsets are: reload 0x00, count 0x04, control 0x08, event status 0x0C, reset status 0x10, unlock 0x14. The unlock register reads as zero. Writes to unmapped offsets are ignored.

Top module: `wdt_dual_timer`

## Requirements
- R1: After reset, every readable register reads zero, the block is in timer mode, and both `irq_o` and `rst_req_o` are low.
- R2: A write to the reload register (0x00) stores the value and also loads it into the count register (0x04). A write to the count register changes only the count.
- R3: While control bit 0 (run) is set, the counter takes one step every (prescaler + 1) clock cycles. The prescaler is control bits [15:8]. With a reload value L, expiry is therefore flagged L×(prescaler+1) cycles after the control write that starts the run.
- R4: While control bit 0 is clear, the count register holds its value.
- R5: In timer mode, a step that takes the count from 1 to 0 sets the sticky event flag (bit 0 at 0x0C). `irq_o` is high exactly while that flag and control bit 2 (interrupt enable) are both set.
- R6: On the step after the count reaches 0, the counter reloads from the reload register if control bit 1 is set (continuous). If bit 1 is clear (single shot), the counter stays at 0.
- R7: In watchdog mode (control bit 3 set), expiry drives `rst_req_o` high for exactly one cycle and sets the sticky reset flag (bit 0 at 0x10). It leaves the event flag unchanged.
- R8: A control write of 1 to bit 3 enters watchdog mode. A control write of 0 to bit 3 is ignored while in watchdog mode.
- R9: Writing 0x12345678 and then 0x87654321 on two successive writes to the unlock register (0x14) clears control bit 3. Any other value, or the two words in the wrong order, returns the unlock detector to its start state. Writes to other registers do not disturb the detector.
- R10: Writing 1 to bit 0 of either status register clears that flag. Writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Timer interrupt (event flag AND interrupt enable) |
| rst_req_o | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
The hardest state to reach from the ports is a half-completed unlock sequence. From outside, an armed detector and an idle one look identical, because the control word shows no difference until the second key arrives. The stimulus therefore drives the block into watchdog mode through a real expiry. It then sends key sequences that must fail: the keys reversed, and the first key followed by a stray value and then the second key. After each one, it confirms from the control readback that watchdog mode is still set. Only then does it send the valid pair. The reset pulse width is observed at the output on every cycle across the expiry.

// File: rtl/wdt_pkg.sv
// Package: shared register offsets, unlock keys and the unlock state type.
// Assumes byte addressing with one register per 32-bit word.
package wdt_pkg;
    localparam int OFS_RELOAD = 'h00;
    localparam int OFS_COUNT  = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_EVENT  = 'h0C;
    localparam int OFS_RSTST  = 'h10;
    localparam int OFS_UNLOCK = 'h14;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_CONT = 1;
    localparam int CTRL_IEN  = 2;
    localparam int CTRL_WDOG = 3;
    localparam int CTRL_PRESC_LSB = 8;

    localparam logic [31:0] UNLOCK_WORD_A = 32'h1234_5678;
    localparam logic [31:0] UNLOCK_WORD_B = 32'h8765_4321;

    typedef enum logic {
        UL_IDLE  = 1'b0,
        UL_ARMED = 1'b1
    } unlock_st_t;
endpackage

// File: rtl/wdt_prescaler.sv
// Module: tick generator. Issues one tick every (limit + 1) clock cycles while
// run is high and restarts its phase whenever run is low.
// Assumes limit is quasi-static. A limit lowered below the current phase
// makes the next tick occur at once.
module wdt_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] limit,
    output logic               tick
);
    logic [PRESC_W-1:0] phase_q;
    logic               wrap;

    // Purpose: detect the last cycle of a prescaler period.
    always_comb begin
        wrap = (phase_q >= limit);
        tick = run && wrap;
    end

    // Purpose: advance the phase, restarting when stopped or at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (wrap) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_down_counter.sv
// Module: the main down counter. Each tick decrements it. A tick that moves it
// from 1 to 0 is an expiry. A tick at 0 reloads it in continuous mode and
// leaves it at 0 otherwise.
// Assumes bus writes take priority over ticks. A write in the same cycle as
// an expiring tick suppresses that expiry.
module wdt_down_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cont,
    input  logic [DATA_W-1:0] reload,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] count,
    output logic              expire
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] count_q;
    logic              at_zero;

    // Purpose: decode expiry and the zero state.
    always_comb begin
        at_zero = (count_q == '0);
        expire  = tick && !wr_en && (count_q == ONE);
        count   = count_q;
    end

    // Purpose: load from the bus, otherwise step on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (wr_en) begin
            count_q <= wr_val;
        end else if (tick) begin
            if (at_zero) begin
                if (cont) begin
                    count_q <= reload;
                end
            end else begin
                count_q <= count_q - ONE;
            end
        end
    end
endmodule

// File: rtl/wdt_unlock.sv
// Module: key sequence detector for leaving watchdog mode. done is high, in
// the same cycle, on the write that completes KEY_A followed by KEY_B.
// Assumes wr_key strobes only on writes to the unlock register. Other bus
// traffic never reaches this module.
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter int                 DATA_W = 32,
    parameter logic [DATA_W-1:0]  KEY_A  = DATA_W'(UNLOCK_WORD_A),
    parameter logic [DATA_W-1:0]  KEY_B  = DATA_W'(UNLOCK_WORD_B)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_key,
    input  logic [DATA_W-1:0] key_data,
    output logic              done
);
    unlock_st_t state_q, state_d;
    logic       is_a, is_b;

    // Purpose: compare the written word with both keys and pick the next state.
    always_comb begin
        is_a    = (key_data == KEY_A);
        is_b    = (key_data == KEY_B);
        state_d = state_q;
        done    = 1'b0;
        if (wr_key) begin
            if (state_q == UL_ARMED && is_b) begin
                done    = 1'b1;
                state_d = UL_IDLE;
            end else if (is_a) begin
                state_d = UL_ARMED;
            end else begin
                state_d = UL_IDLE;
            end
        end
    end

    // Purpose: hold the detector state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/wdt_sticky_flag.sv
// Module: sticky status bit. set wins over a write-one clear in the same cycle.
// Assumes clr is already qualified with the address decode and data bit 0.
module wdt_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Purpose: set on event, clear on write-one, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_dual_timer.sv
// Module: top of the dual-mode timer/watchdog. It decodes the register bus,
// holds the control and reload registers, routes expiry to the event flag
// (timer mode) or to the reset request and reset flag (watchdog mode), and
// keeps the watchdog bit locked until the unlock sequence completes.
// Assumes a single-cycle write strobe and combinational reads, with the reset
// controller consuming a one-cycle request.
module wdt_dual_timer
    import wdt_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_EVENT  = ADDR_W'(OFS_EVENT);
    localparam logic [ADDR_W-1:0] A_RSTST  = ADDR_W'(OFS_RSTST);
    localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFS_UNLOCK);
    localparam int NUM_FLAGS = 2;
    localparam int FLAG_EVT  = 0;
    localparam int FLAG_RST  = 1;

    logic                run_q, cont_q, ien_q, wdog_q;
    logic [PRESC_W-1:0]  presc_q;
    logic [DATA_W-1:0]   reload_q;
    logic [DATA_W-1:0]   count;
    logic                tick, expire, unlock_done;
    logic                wr_reload, wr_count, wr_ctrl, wr_unlock;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
    logic                rst_req_q;
    logic [DATA_W-1:0]   ctrl_view;

    // Purpose: decode which register a write targets.
    always_comb begin
        wr_reload   = bus_wr && (bus_addr == A_RELOAD);
        wr_count    = bus_wr && (bus_addr == A_COUNT);
        wr_ctrl     = bus_wr && (bus_addr == A_CTRL);
        wr_unlock   = bus_wr && (bus_addr == A_UNLOCK);
        flag_clr[FLAG_EVT] = bus_wr && (bus_addr == A_EVENT) && bus_wdata[0];
        flag_clr[FLAG_RST] = bus_wr && (bus_addr == A_RSTST) && bus_wdata[0];
        flag_set[FLAG_EVT] = expire && !wdog_q;
        flag_set[FLAG_RST] = expire && wdog_q;
    end

    // Purpose: control fields; the watchdog bit may be set by a write but only
    // the unlock sequence clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            cont_q  <= 1'b0;
            ien_q   <= 1'b0;
            wdog_q  <= 1'b0;
            presc_q <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q   <= bus_wdata[CTRL_RUN];
                cont_q  <= bus_wdata[CTRL_CONT];
                ien_q   <= bus_wdata[CTRL_IEN];
                presc_q <= bus_wdata[CTRL_PRESC_LSB +: PRESC_W];
            end
            if (unlock_done) begin
                wdog_q <= 1'b0;
            end else if (wr_ctrl && bus_wdata[CTRL_WDOG]) begin
                wdog_q <= 1'b1;
            end
        end
    end

    // Purpose: reload register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_reload) begin
            reload_q <= bus_wdata;
        end
    end

    // Purpose: register the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= flag_set[FLAG_RST];
        end
    end

    wdt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .limit (presc_q),
        .tick  (tick)
    );

    wdt_down_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cont   (cont_q),
        .reload (reload_q),
        .wr_en  (wr_reload || wr_count),
        .wr_val (bus_wdata),
        .count  (count),
        .expire (expire)
    );

    wdt_unlock #(.DATA_W(DATA_W)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_key   (wr_unlock),
        .key_data (bus_wdata),
        .done     (unlock_done)
    );

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
            wdt_sticky_flag u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (flag_set[g]),
                .clr   (flag_clr[g]),
                .q     (flag_q[g])
            );
        end
    endgenerate

    // Purpose: assemble the control word and the read mux.
    always_comb begin
        ctrl_view = '0;
        ctrl_view[CTRL_RUN]  = run_q;
        ctrl_view[CTRL_CONT] = cont_q;
        ctrl_view[CTRL_IEN]  = ien_q;
        ctrl_view[CTRL_WDOG] = wdog_q;
        ctrl_view[CTRL_PRESC_LSB +: PRESC_W] = presc_q;
        unique case (bus_addr)
            A_RELOAD: bus_rdata = reload_q;
            A_COUNT:  bus_rdata = count;
            A_CTRL:   bus_rdata = ctrl_view;
            A_EVENT:  bus_rdata = DATA_W'(flag_q[FLAG_EVT]);
            A_RSTST:  bus_rdata = DATA_W'(flag_q[FLAG_RST]);
            default:  bus_rdata = '0;
        endcase
    end

    // Purpose: drive the outputs.
    always_comb begin
        irq_o     = flag_q[FLAG_EVT] && ien_q;
        rst_req_o = rst_req_q;
    end
endmodule

// File: rtl/wdt_dual_timer_chk.sv
// Module: temporal checks on the dual-mode timer, bound into every instance.
// Assumes it observes internal state through the bind connections only.
module wdt_dual_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              run,
    input logic              wdog,
    input logic              unlock_done,
    input logic              evt_flag,
    input logic              rst_flag,
    input logic              rst_req,
    input logic [DATA_W-1:0] count
);
    // R7: the reset request never lasts two cycles
    assert_req_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: a reset request is always accompanied by the reset flag
    assert_req_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> rst_flag);

    // R7: the event flag never rises out of watchdog mode
    assert_no_event_in_wdog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag) |-> !$past(wdog));

    // R8 and R9: watchdog mode only ends through the unlock sequence
    assert_wdog_exit_by_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog) |-> $past(unlock_done));

    // R4: a stopped counter with no bus write holds its value
    assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr) |=> $stable(count));
endmodule

bind wdt_dual_timer wdt_dual_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .run         (run_q),
    .wdog        (wdog_q),
    .unlock_done (unlock_done),
    .evt_flag    (flag_q[0]),
    .rst_flag    (flag_q[1]),
    .rst_req     (rst_req_o),
    .count       (count)
);

// File: tb/wdt_dual_timer_test.sv
module wdt_dual_timer_test;
    localparam logic [4:0] A_RLD = 5'h00, A_CNT = 5'h04, A_CTL = 5'h08,
                           A_EVT = 5'h0C, A_RST = 5'h10, A_UNL = 5'h14;
    localparam logic [31:0] KA = 32'h1234_5678, KB = 32'h8765_4321;

    typedef struct packed {
        logic [7:0]  presc;
        logic [31:0] reload;
        logic        cont;
    } vec_t;
    localparam int NVEC = 4;
    localparam vec_t VEC [NVEC] = '{
        '{presc: 8'd0, reload: 32'd5, cont: 1'b0},
        '{presc: 8'd2, reload: 32'd4, cont: 1'b1},
        '{presc: 8'd1, reload: 32'd6, cont: 1'b1},
        '{presc: 8'd3, reload: 32'd3, cont: 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, rst_req_o;
    int checks = 0, errors = 0, cycles = 0;

    always #5 clk = ~clk;

    wdt_dual_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: got %0d expected %0d", cycles, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d;
        int n, pulses;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        foreach (VEC[i]) begin end
        rd(A_RLD, d); check("R1 reload", d, 0);
        rd(A_CNT, d); check("R1 count", d, 0);
        rd(A_CTL, d); check("R1 ctrl", d, 0);
        rd(A_EVT, d); check("R1 event", d, 0);
        rd(A_RST, d); check("R1 rstflag", d, 0);
        check("R1 irq", irq_o, 0);
        check("R1 rstreq", rst_req_o, 0);

        // Vector table: R3 latency, R5 flag and irq, R6 reload/hold
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTL, 0);
            wr(A_EVT, 1);
            wr(A_RLD, VEC[i].reload);
            wr(A_CTL, (32'(VEC[i].presc) << 8) | 32'h4 | (32'(VEC[i].cont) << 1) | 32'h1);
            n = 0;
            rd(A_EVT, d);
            while (d[0] !== 1'b1 && n < 2000) begin
                step(1); n++; rd(A_EVT, d);
            end
            check("R3 expiry latency", n, VEC[i].reload * (VEC[i].presc + 1));
            check("R5 irq with enable", irq_o, 1);
            step(VEC[i].presc + 1);
            rd(A_CNT, d);
            check("R6 after zero", d, VEC[i].cont ? VEC[i].reload : 32'd0);
        end
        wr(A_CTL, 0);
        check("R5 irq masked", irq_o, 0);
        rd(A_EVT, d); check("R5 flag sticky", d, 1);
        wr(A_EVT, 1);
        rd(A_EVT, d); check("R10 event clear", d, 0);

        // R2 reload write copies into count; count write leaves reload
        wr(A_RLD, 32'd55);
        rd(A_CNT, d); check("R2 count follows", d, 55);
        wr(A_CNT, 32'd9);
        rd(A_RLD, d); check("R2 reload kept", d, 55);
        // R4 stopped counter holds
        step(6);
        rd(A_CNT, d); check("R4 hold", d, 9);

        // R7 watchdog expiry
        wr(A_RLD, 32'd3);
        wr(A_CTL, 32'h9);
        rd(A_CTL, d); check("R8 enter wdog", d, 32'h9);
        pulses = 0;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (rst_req_o === 1'b1) pulses++;
        end
        check("R7 pulse count", pulses, 1);
        rd(A_RST, d); check("R7 reset flag", d, 1);
        rd(A_EVT, d); check("R7 event untouched", d, 0);
        rd(A_CNT, d); check("R7 stays zero", d, 0);

        // R8 clearing bit 3 via control ignored
        wr(A_CTL, 0);
        rd(A_CTL, d); check("R8 wdog locked", d, 32'h8);

        // R10 reset flag write-0 / write-1
        wr(A_RST, 0);
        rd(A_RST, d); check("R10 write0 keeps", d, 1);
        wr(A_RST, 1);
        rd(A_RST, d); check("R10 write1 clears", d, 0);

        // R9 unlock sequences
        wr(A_UNL, KB); wr(A_UNL, KA);
        rd(A_CTL, d); check("R9 reversed", d, 32'h8);
        wr(A_UNL, 32'd5);
        wr(A_UNL, KA); wr(A_UNL, 32'd3); wr(A_UNL, KB);
        rd(A_CTL, d); check("R9 interrupted", d, 32'h8);
        wr(A_UNL, KA); wr(A_RLD, 32'd2); wr(A_UNL, KB);
        rd(A_CTL, d); check("R9 other reg ignored", d, 32'h0);
        wr(A_CTL, 32'h8);
        wr(A_UNL, KA); wr(A_UNL, KB);
        rd(A_CTL, d); check("R9 valid pair", d, 32'h0);
        rd(A_UNL, d); check("R9 unlock reads zero", d, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule